// File: doc/BRIEF.md
# Calendar Update and Alarm Engine

This block keeps the time of day and the calendar date for a real-time clock. Seconds, minutes, hours, weekday, day of month, month and a two-digit year are held internally as plain binary. On every accepted 1 Hz strobe the block advances the time by one second. The carries run through minutes, hours and days, and then through months and years. Month lengths are honoured, and February gets a leap day by the full Gregorian rule, applied to a full year formed from a base-year parameter plus the two-digit year.

The host sees seven time bytes, and their encoding follows two mode inputs: packed BCD or plain binary, and 12-hour or 24-hour hours. Each accepted strobe opens an update window. An update-in-progress flag covers the window, and at its end the visible bytes are refreshed. At that same point the block compares the time with three alarm bytes, any of which may be a wildcard, and pulses its update-ended, alarm and interrupt-request strobes. A set-mode input freezes the visible bytes so that software can write a whole new time. That time takes effect when set mode is left.

Top module: `rtc_cal_engine`

## Requirements
- R1: After reset the seconds, minutes, hours and year bytes read 0. The weekday, day and month bytes read 1. The update-in-progress flag and all three strobes are low.
- R2: A strobe on `tick_1hz` is accepted only when `osc_sel` equals 3'b010. With any other value the strobe has no effect: time does not advance, the update-in-progress flag stays low and no strobe is produced.
- R3: Seconds and minutes wrap from 59 to 0 and carry onward. Hours wrap from 23 to 0 and carry into the date.
- R4: The weekday counts 1 to 7, and it steps to 1 after 7 (or after any value of 7 or more) on each day change.
- R5: The day of month wraps to 1 after the last day of the month, which is 30 for months 4, 6, 9 and 11, 28 or 29 for month 2, and 31 otherwise. The month wraps from 12 to 1 and increments the year, and the year wraps from 99 to 0.
- R6: February has 29 days when the full year (parameter `BASE_YEAR` plus the year byte) is divisible by 400, or is divisible by 4 but not by 100.
- R7: With `bin_mode`=0 each byte is packed BCD, with tens in bits 7:4 and units in bits 3:0. With `bin_mode`=1 each byte is plain binary. A change of `bin_mode` or `h24_mode` while `set_mode` is low re-encodes the visible bytes one cycle later.
- R8: With `h24_mode`=0 the hours byte holds the hour modulo 12 in bits 6:0, with bit 7 set for hours 12 to 23, so midnight reads 0x00 and noon 0x80. When an hours byte is loaded, bit 7 adds 12 hours.
- R9: An accepted strobe with `set_mode` low raises `uip` on the next cycle and holds it for `UIP_CYCLES` cycles. `uip` falls in the same cycle as the visible bytes are refreshed and `upd_done` pulses. While `set_mode` is high, `uip` stays low and the visible bytes are not refreshed.
- R10: A load on `ld_en` writes byte `ld_sel` (0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day, 5 month, 6 year) in the current encoding. With `set_mode` low the internal time is reloaded from the visible bytes at once. With `set_mode` high the reload waits until `set_mode` falls.
- R11: At the end of each update window the alarm matches when each of the three alarm bytes either has bits 7:6 both set (a wildcard) or decodes to the current field. On a match with `alm_irq_en` high, `alm_hit` and `irq_req` pulse.
- R12: `upd_done` pulses for one cycle at the end of every update window. `irq_req` pulses with it when `upd_irq_en` is high.
- R13: A day-of-month value of 0 advances to 1 without a month carry. A month value outside 1 to 12 is given 31 days, and any month above 12 wraps to 1 with a year carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1hz | input | 1 | One-cycle strobe, once per second |
| osc_sel | input | 3 | Oscillator control; 3'b010 lets time run |
| set_mode | input | 1 | Freezes the visible bytes and suppresses update-in-progress |
| bin_mode | input | 1 | 1 for binary bytes, 0 for packed BCD |
| h24_mode | input | 1 | 1 for 24-hour hours, 0 for 12-hour with PM bit |
| upd_irq_en | input | 1 | Update-ended interrupt enable |
| alm_irq_en | input | 1 | Alarm interrupt enable |
| ld_en | input | 1 | Load strobe for one time byte |
| ld_sel | input | 3 | Byte selected by a load |
| ld_data | input | 8 | Byte value for a load |
| alm_sec | input | 8 | Seconds alarm byte |
| alm_min | input | 8 | Minutes alarm byte |
| alm_hour | input | 8 | Hours alarm byte |
| out_sec | output | 8 | Visible seconds |
| out_min | output | 8 | Visible minutes |
| out_hour | output | 8 | Visible hours |
| out_wday | output | 8 | Visible weekday |
| out_mday | output | 8 | Visible day of month |
| out_mon | output | 8 | Visible month |
| out_year | output | 8 | Visible two-digit year |
| uip | output | 1 | Update in progress |
| upd_done | output | 1 | Update-ended strobe |
| alm_hit | output | 1 | Alarm strobe |
| irq_req | output | 1 | Interrupt-request strobe |

## Verification
The alarm check and the update-ended report both fall at the end of the same update window, and they share the one interrupt-request strobe. The bench arms an alarm whose seconds byte equals the next second and whose minutes and hours bytes are wildcards, with both interrupt enables on. It then requires that `upd_done`, `alm_hit` and `irq_req` each pulse exactly once in that window. Further windows switch one enable off at a time, or break the match, to show that each source drives `irq_req` on its own.

// File: rtl/rtc_cal_pkg.sv
`timescale 1ns/1ps
// Shared types and encoding helpers for the calendar engine.
// Assumes every time field fits one byte; the BCD helpers work modulo 100.
package rtc_cal_pkg;

    localparam int FIELDS   = 7;
    localparam int IDX_SEC  = 0;
    localparam int IDX_MIN  = 1;
    localparam int IDX_HOUR = 2;

    // Declared year first so that bit-slice index 0 is seconds.
    typedef struct packed {
        logic [7:0] year;
        logic [7:0] mon;
        logic [7:0] mday;
        logic [7:0] wday;
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } cal_t;

    typedef logic [FIELDS-1:0][7:0] regs_t;

    localparam cal_t CAL_RST = '{year: 8'd0, mon: 8'd1, mday: 8'd1, wday: 8'd1,
                                 hour: 8'd0, min: 8'd0, sec: 8'd0};

    function automatic logic [7:0] bin2bcd(input logic [7:0] v);
        logic [7:0] t;
        logic [7:0] tens;
        logic [7:0] units;
        t     = v % 8'd100;
        tens  = t / 8'd10;
        units = t % 8'd10;
        return {tens[3:0], units[3:0]};
    endfunction

    function automatic logic [7:0] bcd2bin(input logic [7:0] b);
        return ({4'd0, b[7:4]} * 8'd10) + {4'd0, b[3:0]};
    endfunction

    function automatic logic [7:0] enc_val(input logic [7:0] v, input logic bin);
        return bin ? v : bin2bcd(v);
    endfunction

    function automatic logic [7:0] dec_val(input logic [7:0] b, input logic bin);
        return bin ? b : bcd2bin(b);
    endfunction

    function automatic logic [7:0] enc_hour(input logic [7:0] h, input logic bin,
                                            input logic h24);
        if (h24)
            return enc_val(h, bin);
        return enc_val(h % 8'd12, bin) | ((h >= 8'd12) ? 8'h80 : 8'h00);
    endfunction

    function automatic logic [7:0] dec_hour(input logic [7:0] b, input logic bin,
                                            input logic h24);
        logic [7:0] v;
        v = dec_val({1'b0, b[6:0]}, bin);
        if (!h24 && b[7])
            v = v + 8'd12;
        return v;
    endfunction

endpackage

// File: rtl/rtc_cal_step.sv
`timescale 1ns/1ps
// Next-second calculator: pure combinational advance of a binary calendar.
// Assumes the year field is an offset from BASE_YEAR, kept modulo 100.
module rtc_cal_step
    import rtc_cal_pkg::*;
#(
    parameter int BASE_YEAR = 1980
) (
    input  cal_t cur,
    output cal_t nxt
);
    localparam logic [15:0] BASE16 = 16'(BASE_YEAR);

    logic [15:0] full_year;
    logic        leap;
    logic [7:0]  dim;

    // Full year and the Gregorian leap test.
    always_comb begin
        full_year = BASE16 + {8'd0, cur.year};
        leap = ((full_year % 16'd4) == 16'd0) &&
               (((full_year % 16'd100) != 16'd0) || ((full_year % 16'd400) == 16'd0));
    end

    // Length of the current month; unknown months get 31 days.
    always_comb begin
        case (cur.mon)
            8'd2:                      dim = leap ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11:   dim = 8'd30;
            default:                   dim = 8'd31;
        endcase
    end

    // Carry chain from seconds up to the year.
    always_comb begin
        nxt = cur;
        if (({1'b0, cur.sec} + 9'd1) < 9'd60) begin
            nxt.sec = cur.sec + 8'd1;
        end else begin
            nxt.sec = 8'd0;
            if (({1'b0, cur.min} + 9'd1) < 9'd60) begin
                nxt.min = cur.min + 8'd1;
            end else begin
                nxt.min = 8'd0;
                if (({1'b0, cur.hour} + 9'd1) < 9'd24) begin
                    nxt.hour = cur.hour + 8'd1;
                end else begin
                    nxt.hour = 8'd0;
                    nxt.wday = (cur.wday >= 8'd7) ? 8'd1 : cur.wday + 8'd1;
                    if (({1'b0, cur.mday} + 9'd1) <= {1'b0, dim}) begin
                        nxt.mday = cur.mday + 8'd1;
                    end else begin
                        nxt.mday = 8'd1;
                        if (({1'b0, cur.mon} + 9'd1) <= 9'd12) begin
                            nxt.mon = cur.mon + 8'd1;
                        end else begin
                            nxt.mon  = 8'd1;
                            nxt.year = 8'(({1'b0, cur.year} + 9'd1) % 9'd100);
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/rtc_cal_codec.sv
`timescale 1ns/1ps
// Encoder: binary calendar to visible bytes in the selected format.
// Assumes hours are 0..23 internally; the other fields pass through enc_val.
module rtc_cal_encode
    import rtc_cal_pkg::*;
(
    input  cal_t  tm,
    input  logic  bin_mode,
    input  logic  h24_mode,
    output regs_t regs
);
    regs_t vals;
    assign vals = regs_t'(tm);

    for (genvar i = 0; i < FIELDS; i++) begin : g_enc
        if (i == IDX_HOUR) begin : g_hour
            assign regs[i] = enc_hour(vals[i], bin_mode, h24_mode);
        end else begin : g_plain
            assign regs[i] = enc_val(vals[i], bin_mode);
        end
    end

endmodule

// Decoder: visible bytes back to a binary calendar.
// Assumes the bytes were written in the currently selected format.
module rtc_cal_decode
    import rtc_cal_pkg::*;
(
    input  regs_t regs,
    input  logic  bin_mode,
    input  logic  h24_mode,
    output cal_t  tm
);
    regs_t vals;
    assign tm = cal_t'(vals);

    for (genvar i = 0; i < FIELDS; i++) begin : g_dec
        if (i == IDX_HOUR) begin : g_hour
            assign vals[i] = dec_hour(regs[i], bin_mode, h24_mode);
        end else begin : g_plain
            assign vals[i] = dec_val(regs[i], bin_mode);
        end
    end

endmodule

// File: rtl/rtc_alarm_match.sv
`timescale 1ns/1ps
// Alarm comparator over seconds, minutes and hours.
// A byte with both top bits set is a wildcard; others decode in the current format.
module rtc_alarm_match
    import rtc_cal_pkg::*;
#(
    parameter int NCMP = 3
) (
    input  logic [NCMP-1:0][7:0] alm,
    input  cal_t                 tm,
    input  logic                 bin_mode,
    input  logic                 h24_mode,
    output logic                 match
);
    regs_t            cur;
    logic [NCMP-1:0]  hit;

    assign cur = regs_t'(tm);

    for (genvar i = 0; i < NCMP; i++) begin : g_cmp
        logic       wild;
        logic [7:0] want;
        assign wild = (alm[i][7:6] == 2'b11);
        if (i == IDX_HOUR) begin : g_hour
            assign want = dec_hour(alm[i], bin_mode, h24_mode);
        end else begin : g_plain
            assign want = dec_val(alm[i], bin_mode);
        end
        assign hit[i] = wild || (want == cur[i]);
    end

    assign match = &hit;

endmodule

// File: rtl/rtc_cal_engine.sv
`timescale 1ns/1ps
// Calendar update and alarm engine (top).
// Advances a binary calendar on each accepted 1 Hz strobe, runs an
// update-in-progress window of UIP_CYCLES clocks, then refreshes the visible
// bytes, checks the alarm and pulses the status strobes.
// Assumes tick_1hz is a single-cycle pulse spaced far wider than the window.
module rtc_cal_engine
    import rtc_cal_pkg::*;
#(
    parameter int BASE_YEAR  = 1980,
    parameter int UIP_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_1hz,
    input  logic [2:0] osc_sel,
    input  logic       set_mode,
    input  logic       bin_mode,
    input  logic       h24_mode,
    input  logic       upd_irq_en,
    input  logic       alm_irq_en,
    input  logic       ld_en,
    input  logic [2:0] ld_sel,
    input  logic [7:0] ld_data,
    input  logic [7:0] alm_sec,
    input  logic [7:0] alm_min,
    input  logic [7:0] alm_hour,
    output logic [7:0] out_sec,
    output logic [7:0] out_min,
    output logic [7:0] out_hour,
    output logic [7:0] out_wday,
    output logic [7:0] out_mday,
    output logic [7:0] out_mon,
    output logic [7:0] out_year,
    output logic       uip,
    output logic       upd_done,
    output logic       alm_hit,
    output logic       irq_req
);
    localparam int          CW       = $clog2(UIP_CYCLES + 1);
    localparam logic [CW-1:0] LAST   = CW'(UIP_CYCLES - 1);
    localparam logic [2:0]  OSC_RUN  = 3'b010;

    cal_t        cal_q, cal_adv, cal_parsed;
    regs_t       vis_q, vis_ld, vis_enc;
    logic        set_q;
    logic [1:0]  fmt_q;
    logic        busy_q;
    logic [CW-1:0] cnt_q;
    logic        accept, win_end, fmt_chg, alm_match;

    assign accept  = tick_1hz && (osc_sel == OSC_RUN);
    assign win_end = busy_q && (cnt_q == LAST);
    assign fmt_chg = (fmt_q != {bin_mode, h24_mode});

    // Visible bytes with the pending load byte substituted.
    always_comb begin
        vis_ld = vis_q;
        if (ld_en && (ld_sel < 3'(FIELDS)))
            vis_ld[ld_sel] = ld_data;
    end

    rtc_cal_step #(.BASE_YEAR(BASE_YEAR)) u_step (
        .cur (cal_q),
        .nxt (cal_adv)
    );

    rtc_cal_encode u_enc (
        .tm       (cal_q),
        .bin_mode (bin_mode),
        .h24_mode (h24_mode),
        .regs     (vis_enc)
    );

    rtc_cal_decode u_dec (
        .regs     (vis_ld),
        .bin_mode (bin_mode),
        .h24_mode (h24_mode),
        .tm       (cal_parsed)
    );

    rtc_alarm_match #(.NCMP(3)) u_alm (
        .alm      ({alm_hour, alm_min, alm_sec}),
        .tm       (cal_q),
        .bin_mode (bin_mode),
        .h24_mode (h24_mode),
        .match    (alm_match)
    );

    // Internal binary time: reload from the bytes, else advance on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cal_q <= CAL_RST;
        else if ((ld_en || set_q) && !set_mode)
            cal_q <= cal_parsed;
        else if (accept)
            cal_q <= cal_adv;
    end

    // Mode history used to spot set-mode exit and format changes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_q <= 1'b0;
            fmt_q <= 2'b00;
        end else begin
            set_q <= set_mode;
            fmt_q <= {bin_mode, h24_mode};
        end
    end

    // Update window sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end else if (win_end) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Update-in-progress flag, held low in set mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            uip <= 1'b0;
        else if (set_mode)
            uip <= 1'b0;
        else if (accept)
            uip <= 1'b1;
        else if (win_end)
            uip <= 1'b0;
    end

    // Visible bytes: loads, end-of-window refresh, format re-encode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vis_q <= regs_t'(CAL_RST);
        else if (ld_en)
            vis_q <= vis_ld;
        else if ((win_end || fmt_chg) && !set_mode)
            vis_q <= vis_enc;
    end

    // End-of-window status strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_done <= 1'b0;
            alm_hit  <= 1'b0;
            irq_req  <= 1'b0;
        end else begin
            upd_done <= win_end;
            alm_hit  <= win_end && alm_irq_en && alm_match;
            irq_req  <= win_end && (upd_irq_en || (alm_irq_en && alm_match));
        end
    end

    assign out_sec  = vis_q[0];
    assign out_min  = vis_q[1];
    assign out_hour = vis_q[2];
    assign out_wday = vis_q[3];
    assign out_mday = vis_q[4];
    assign out_mon  = vis_q[5];
    assign out_year = vis_q[6];

endmodule

// File: rtl/rtc_cal_chk.sv
`timescale 1ns/1ps
// Protocol checker for rtc_cal_engine, attached by bind; observes ports only.
module rtc_cal_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_1hz,
    input logic [2:0] osc_sel,
    input logic       set_mode,
    input logic       bin_mode,
    input logic       ld_en,
    input logic [7:0] out_sec,
    input logic       uip,
    input logic       upd_done,
    input logic       alm_hit,
    input logic       irq_req
);
    // R2
    osc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1hz && (osc_sel != 3'b010) && !uip) |=> !uip);

    // R9
    uip_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1hz && (osc_sel == 3'b010) && !set_mode) |=> uip);

    // R9
    set_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_mode |=> !uip);

    // R9
    uip_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(uip) && !$past(set_mode)) |-> upd_done);

    // R11
    alm_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alm_hit |-> (irq_req && upd_done));

    // R12
    irq_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> upd_done);

    // R7
    bcd_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_done && !$past(bin_mode) && !$past(set_mode) && !$past(ld_en))
            |-> (out_sec[3:0] <= 4'd9));

endmodule

bind rtc_cal_engine rtc_cal_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_1hz (tick_1hz),
    .osc_sel  (osc_sel),
    .set_mode (set_mode),
    .bin_mode (bin_mode),
    .ld_en    (ld_en),
    .out_sec  (out_sec),
    .uip      (uip),
    .upd_done (upd_done),
    .alm_hit  (alm_hit),
    .irq_req  (irq_req)
);

// File: tb/tb_rtc_cal_engine.sv
`timescale 1ns/1ps
module tb_rtc_cal_engine;

    localparam int UIPN = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0;
    logic [2:0] osc_sel = 3'b010;
    logic       set_mode = 1'b0, bin_mode = 1'b1, h24_mode = 1'b1;
    logic       upd_irq_en = 1'b0, alm_irq_en = 1'b0;
    logic       ld_en = 1'b0;
    logic [2:0] ld_sel = 3'd0;
    logic [7:0] ld_data = 8'd0;
    logic [7:0] alm_sec = 8'd0, alm_min = 8'd0, alm_hour = 8'd0;
    logic [7:0] o_sec, o_min, o_hour, o_wday, o_mday, o_mon, o_year;
    logic       uip, upd_done, alm_hit, irq_req;
    logic [7:0] c_sec, c_min, c_hour, c_wday, c_mday, c_mon, c_year;
    logic       c_uip, c_upd, c_alm, c_irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    rtc_cal_engine #(.BASE_YEAR(1980), .UIP_CYCLES(UIPN)) dut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .osc_sel(osc_sel),
        .set_mode(set_mode), .bin_mode(bin_mode), .h24_mode(h24_mode),
        .upd_irq_en(upd_irq_en), .alm_irq_en(alm_irq_en),
        .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
        .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour),
        .out_sec(o_sec), .out_min(o_min), .out_hour(o_hour), .out_wday(o_wday),
        .out_mday(o_mday), .out_mon(o_mon), .out_year(o_year),
        .uip(uip), .upd_done(upd_done), .alm_hit(alm_hit), .irq_req(irq_req)
    );

    // Second instance with a base year that puts a century year in range.
    rtc_cal_engine #(.BASE_YEAR(2080), .UIP_CYCLES(UIPN)) dut_c (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .osc_sel(osc_sel),
        .set_mode(set_mode), .bin_mode(bin_mode), .h24_mode(h24_mode),
        .upd_irq_en(upd_irq_en), .alm_irq_en(alm_irq_en),
        .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
        .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour),
        .out_sec(c_sec), .out_min(c_min), .out_hour(c_hour), .out_wday(c_wday),
        .out_mday(c_mday), .out_mon(c_mon), .out_year(c_year),
        .uip(c_uip), .upd_done(c_upd), .alm_hit(c_alm), .irq_req(c_irq)
    );

    // {start sec,min,hour,wday,mday,mon,year, expected same seven}, binary 24h
    localparam logic [111:0] VEC [13] = '{
        {8'd30,8'd20,8'd10,8'd3,8'd15,8'd6,8'd40,  8'd31,8'd20,8'd10,8'd3,8'd15,8'd6,8'd40},
        {8'd59,8'd5,8'd0,8'd2,8'd9,8'd9,8'd9,      8'd0,8'd6,8'd0,8'd2,8'd9,8'd9,8'd9},
        {8'd59,8'd59,8'd12,8'd4,8'd1,8'd7,8'd30,   8'd0,8'd0,8'd13,8'd4,8'd1,8'd7,8'd30},
        {8'd59,8'd59,8'd23,8'd7,8'd31,8'd12,8'd99, 8'd0,8'd0,8'd0,8'd1,8'd1,8'd1,8'd0},
        {8'd59,8'd59,8'd23,8'd2,8'd28,8'd2,8'd20,  8'd0,8'd0,8'd0,8'd3,8'd29,8'd2,8'd20},
        {8'd59,8'd59,8'd23,8'd5,8'd28,8'd2,8'd21,  8'd0,8'd0,8'd0,8'd6,8'd1,8'd3,8'd21},
        {8'd59,8'd59,8'd23,8'd1,8'd29,8'd2,8'd24,  8'd0,8'd0,8'd0,8'd2,8'd1,8'd3,8'd24},
        {8'd59,8'd59,8'd23,8'd6,8'd30,8'd4,8'd5,   8'd0,8'd0,8'd0,8'd7,8'd1,8'd5,8'd5},
        {8'd59,8'd59,8'd23,8'd3,8'd31,8'd1,8'd10,  8'd0,8'd0,8'd0,8'd4,8'd1,8'd2,8'd10},
        {8'd59,8'd59,8'd23,8'd3,8'd0,8'd3,8'd10,   8'd0,8'd0,8'd0,8'd4,8'd1,8'd3,8'd10},
        {8'd59,8'd59,8'd23,8'd3,8'd30,8'd0,8'd10,  8'd0,8'd0,8'd0,8'd4,8'd31,8'd0,8'd10},
        {8'd59,8'd59,8'd23,8'd3,8'd31,8'd13,8'd10, 8'd0,8'd0,8'd0,8'd4,8'd1,8'd1,8'd11},
        {8'd59,8'd59,8'd23,8'd6,8'd30,8'd9,8'd15,  8'd0,8'd0,8'd0,8'd7,8'd1,8'd10,8'd15}
    };

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic load_byte(input logic [2:0] sel, input logic [7:0] val);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = sel; ld_data = val;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic load_all(input logic [55:0] v);
        for (int f = 0; f < 7; f++)
            load_byte(3'(f), v[55-8*f -: 8]);
    endtask

    // Pulse the strobe and count what each output does over the window.
    task automatic run_upd(output int n_uip, output int n_upd, output int n_alm,
                           output int n_irq);
        n_uip = 0; n_upd = 0; n_alm = 0; n_irq = 0;
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
        for (int i = 0; i < UIPN + 6; i++) begin
            n_uip += int'(uip);
            n_upd += int'(upd_done);
            n_alm += int'(alm_hit);
            n_irq += int'(irq_req);
            @(negedge clk);
        end
    endtask

    function automatic logic [55:0] vis();
        return {o_sec, o_min, o_hour, o_wday, o_mday, o_mon, o_year};
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stim
        int nu, nd, na, ni;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(vis() == {8'd0,8'd0,8'd0,8'd1,8'd1,8'd1,8'd0}, "R1 reset bytes",
            64'(vis()), 64'h00000001010100);
        chk(uip == 1'b0, "R1 uip after reset", 64'(uip), 0);
        chk({upd_done, alm_hit, irq_req} == 3'b000, "R1 strobes after reset",
            64'({upd_done, alm_hit, irq_req}), 0);

        // Vector table: R3 R4 R5 R6 R13, binary 24-hour
        for (int k = 0; k < 13; k++) begin
            load_all(VEC[k][111:56]);
            run_upd(nu, nd, na, ni);
            chk(vis() == VEC[k][55:0], $sformatf("R3 R4 R5 R6 R13 vector %0d", k),
                64'(vis()), 64'(VEC[k][55:0]));
            if (k == 0) begin
                chk(nu == UIPN, "R9 uip window length", 64'(nu), 64'(UIPN));
                chk(nd == 1, "R12 one upd_done per update", 64'(nd), 1);
            end
            if (k == 4)
                chk({c_mday, c_mon} == {8'd1, 8'd3}, "R6 century year not leap",
                    64'({c_mday, c_mon}), 64'h0103);
        end

        // R2 oscillator gate
        load_byte(3'd0, 8'd10);
        osc_sel = 3'b110;
        run_upd(nu, nd, na, ni);
        chk(o_sec == 8'd10, "R2 time frozen", 64'(o_sec), 10);
        chk(nu == 0 && nd == 0, "R2 no window when stopped", 64'(nu + nd), 0);
        osc_sel = 3'b010;

        // R7 BCD encoding and re-encode on format change
        bin_mode = 1'b0;
        repeat (2) @(negedge clk);
        load_byte(3'd0, 8'h45);
        run_upd(nu, nd, na, ni);
        chk(o_sec == 8'h46, "R7 BCD seconds", 64'(o_sec), 64'h46);
        bin_mode = 1'b1;
        repeat (2) @(negedge clk);
        chk(o_sec == 8'd46, "R7 re-encode to binary", 64'(o_sec), 46);
        bin_mode = 1'b0;
        repeat (2) @(negedge clk);
        load_byte(3'd0, 8'h59); load_byte(3'd1, 8'h59); load_byte(3'd2, 8'h09);
        run_upd(nu, nd, na, ni);
        chk({o_hour, o_min, o_sec} == 24'h100000, "R7 BCD tens carry",
            64'({o_hour, o_min, o_sec}), 64'h100000);

        // R8 12-hour mode (BCD)
        h24_mode = 1'b0;
        repeat (2) @(negedge clk);
        load_byte(3'd0, 8'h59); load_byte(3'd1, 8'h59); load_byte(3'd2, 8'h91);
        run_upd(nu, nd, na, ni);
        chk(o_hour == 8'h00, "R8 11PM to midnight", 64'(o_hour), 0);
        load_byte(3'd0, 8'h59); load_byte(3'd1, 8'h59); load_byte(3'd2, 8'h11);
        run_upd(nu, nd, na, ni);
        chk(o_hour == 8'h80, "R8 11AM to noon", 64'(o_hour), 64'h80);
        h24_mode = 1'b1;
        repeat (2) @(negedge clk);
        chk(o_hour == 8'h12, "R8 noon in 24-hour", 64'(o_hour), 64'h12);

        // R12 update-ended interrupt enable
        bin_mode = 1'b1;
        repeat (2) @(negedge clk);
        run_upd(nu, nd, na, ni);
        chk(nd == 1 && ni == 0, "R12 no irq when disabled", 64'(ni), 0);
        upd_irq_en = 1'b1;
        run_upd(nu, nd, na, ni);
        chk(nd == 1 && ni == 1, "R12 irq when enabled", 64'(ni), 1);

        // R11 alarm with wildcards, coinciding with update-ended
        load_byte(3'd0, 8'd29); load_byte(3'd1, 8'd20); load_byte(3'd2, 8'd10);
        alm_sec = 8'd30; alm_min = 8'hC0; alm_hour = 8'hC5; alm_irq_en = 1'b1;
        run_upd(nu, nd, na, ni);
        chk(na == 1 && nd == 1 && ni == 1, "R11 wildcard alarm with update",
            64'({na[7:0], nd[7:0], ni[7:0]}), 64'h010101);
        upd_irq_en = 1'b0;
        alm_sec = 8'd31; alm_hour = 8'd11;
        run_upd(nu, nd, na, ni);
        chk(na == 0 && ni == 0, "R11 hour mismatch no alarm", 64'(na + ni), 0);
        alm_irq_en = 1'b0;
        alm_sec = 8'd32; alm_min = 8'd20; alm_hour = 8'd10;
        run_upd(nu, nd, na, ni);
        chk(na == 0 && ni == 0, "R11 match ignored when disabled", 64'(na + ni), 0);
        alm_irq_en = 1'b1;
        alm_sec = 8'd33;
        run_upd(nu, nd, na, ni);
        chk(na == 1 && ni == 1, "R11 exact match alone", 64'(na + ni), 2);
        alm_irq_en = 1'b0;

        // R9 R10 set mode
        load_byte(3'd0, 8'd10);
        set_mode = 1'b1;
        @(negedge clk);
        run_upd(nu, nd, na, ni);
        chk(nu == 0, "R9 no uip in set mode", 64'(nu), 0);
        chk(o_sec == 8'd10 && nd == 1, "R9 bytes frozen in set mode", 64'(o_sec), 10);
        load_byte(3'd0, 8'd40);
        set_mode = 1'b0;
        repeat (2) @(negedge clk);
        run_upd(nu, nd, na, ni);
        chk(o_sec == 8'd41, "R10 reload on set exit", 64'(o_sec), 41);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule